// File: doc/BRIEF.md
# Instruction Mix Counter

This block steps through a program held in an external instruction memory and tallies how many instructions of each kind the program contains. It never executes anything. Each clock cycle it presents a word address, takes the 32-bit instruction word that the memory returns in the same cycle, and sorts that word into one of eight instruction classes. It then increments the counter for that class and a running total.

A fixed end-of-program word stops the walk. The block then raises its done flag and holds every counter and the address at their final values until the next clear. If the program runs to the last memory row without this end word, the block counts that last row and stops there. All counters saturate at their maximum value.

Top module: `instr_mix_counter`

## Requirements
- R1: While `clr` is high at a rising clock edge, `mem_addr`, all eight class counts, `total_count` and `done` become zero.
- R2: While `done` is low and the current word is not the end word, `mem_addr` advances by one on each rising edge, as long as it is below the last row.
- R3: The class code comes from opcode bits [6:0] and, for the jump opcode, from destination bits [11:7]. The codes are 0x13→0, 0x33→1, 0x03→2, 0x23→3, 0x63→4, 0x6F with destination≠0→5, 0x6F with destination=0→6, 0x67→7. Count k occupies `type_counts[16k+15:16k]`.
- R4: For each counted word, exactly one class count rises by one, and all other class counts keep their values.
- R5: A word whose opcode matches none of the eight classes increments `total_count` but leaves every class count unchanged.
- R6: Only the full 32-bit word 0xC0001073 is the end word. Reading it sets `done`, and the word itself is not counted. Words that differ from it in any bit are classified normally.
- R7: Once `done` is high, it stays high, and `mem_addr` and every count stay frozen until `clr`.
- R8: If the word at the last row (255) is not the end word, it is counted, `done` is set, and `mem_addr` stays at 255.
- R9: Each count is `COUNT_W` bits wide (16 by default) and holds at its all-ones value instead of wrapping.
- R10: `total_count` increments once for every counted word, whatever its class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clr | input | 1 | Synchronous active-high clear |
| mem_addr | output | 8 | Word address to the instruction memory |
| instr_word | input | 32 | Instruction word read at `mem_addr` in the same cycle |
| type_counts | output | 128 | Eight packed 16-bit class counts, class 0 in the low bits |
| total_count | output | 16 | Count of all words counted |
| done | output | 1 | End word found or last row counted |

## Verification
The assertions check on every cycle:
- the address stepping and the stop at the last row;
- that `done` holds and the address freezes once it is set;
- that a counter moves only by one when enabled, holds when not enabled, and holds once saturated;
- that the class decoder never enables more than one counter;
- that the jump opcode with a zero destination resolves to class 6.

Only the bench scenarios can show that each count adds up to the right value for a whole program. The same goes for three word types:
- unknown opcodes, which add to the total alone;
- words close to the end word, which are still counted;
- an end word at the first row, which stops the walk at once.

A narrow-counter instance shows saturation, which the default widths cannot reach within 256 rows.

// File: rtl/mix_pkg.sv
package mix_pkg;
  localparam int TYPE_W  = 3;
  localparam int NTYPES  = 1 << TYPE_W;
  localparam int WORD_W  = 32;

  localparam logic [WORD_W-1:0] END_WORD = 32'hC000_1073;

  localparam logic [6:0] OPC_ALU_IMM = 7'h13;
  localparam logic [6:0] OPC_ALU_REG = 7'h33;
  localparam logic [6:0] OPC_LOAD    = 7'h03;
  localparam logic [6:0] OPC_STORE   = 7'h23;
  localparam logic [6:0] OPC_BRANCH  = 7'h63;
  localparam logic [6:0] OPC_JUMP    = 7'h6F;
  localparam logic [6:0] OPC_JUMP_R  = 7'h67;

  typedef enum logic [TYPE_W-1:0] {
    CLS_ALU_IMM = 3'd0,
    CLS_ALU_REG = 3'd1,
    CLS_LOAD    = 3'd2,
    CLS_STORE   = 3'd3,
    CLS_BRANCH  = 3'd4,
    CLS_CALL    = 3'd5,
    CLS_JUMP    = 3'd6,
    CLS_JUMP_R  = 3'd7
  } cls_e;
endpackage

// File: rtl/mix_classifier.sv
module mix_classifier
  import mix_pkg::*;
(
  input  logic [11:0]       word_lo,
  output logic [TYPE_W-1:0] cls_code,
  output logic              cls_hit
);
  logic [6:0]        opc;
  logic [4:0]        dest;
  logic              dest_zero;
  logic [NTYPES-1:0] match;

  assign opc       = word_lo[6:0];
  assign dest      = word_lo[11:7];
  assign dest_zero = (dest == 5'd0);

  // One comparator per class; the two jump classes overlap on purpose.
  always_comb begin
    match              = '0;
    match[CLS_ALU_IMM] = (opc == OPC_ALU_IMM);
    match[CLS_ALU_REG] = (opc == OPC_ALU_REG);
    match[CLS_LOAD]    = (opc == OPC_LOAD);
    match[CLS_STORE]   = (opc == OPC_STORE);
    match[CLS_BRANCH]  = (opc == OPC_BRANCH);
    match[CLS_CALL]    = (opc == OPC_JUMP);
    match[CLS_JUMP]    = (opc == OPC_JUMP) && dest_zero;
    match[CLS_JUMP_R]  = (opc == OPC_JUMP_R);
  end

  // Priority encoder: the highest asserted index wins.
  always_comb begin
    cls_code = '0;
    for (int i = 0; i < NTYPES; i++) begin
      if (match[i]) cls_code = i[TYPE_W-1:0];
    end
  end

  assign cls_hit = |match;

  always_comb begin
    if (opc == OPC_JUMP && dest_zero) begin
      assert_jump_wins_R3: assert (cls_code == CLS_JUMP && cls_hit);
    end
  end
endmodule

// File: rtl/mix_decoder.sv
module mix_decoder #(
  parameter int SEL_W = 3,
  localparam int NOUT = 1 << SEL_W
) (
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic [NOUT-1:0]  onehot
);
  for (genvar g = 0; g < NOUT; g++) begin : g_line
    assign onehot[g] = en && (sel == SEL_W'(g));
  end

  always_comb begin
    assert_single_enable_R4: assert ($onehot0(onehot));
  end
endmodule

// File: rtl/mix_sat_counter.sv
module mix_sat_counter #(
  parameter int W = 16,
  localparam logic [W-1:0] TOP = {W{1'b1}}
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (clr) begin
      count <= '0;
    end else if (inc && count != TOP) begin
      count <= count + 1'b1;
    end
  end

  assert_hold_at_top_R9: assert property (@(posedge clk) disable iff (clr)
    (count == TOP) |=> (count == TOP));

  assert_step_by_one_R4: assert property (@(posedge clk) disable iff (clr)
    (inc && count != TOP) |=> (count == W'($past(count) + 1'b1)));

  assert_idle_holds_R4: assert property (@(posedge clk) disable iff (clr)
    (!inc) |=> $stable(count));
endmodule

// File: rtl/instr_mix_counter.sv
module instr_mix_counter
  import mix_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int COUNT_W = 16,
  localparam int CNT_BUS = NTYPES * COUNT_W,
  localparam logic [ADDR_W-1:0] LAST_ROW = {ADDR_W{1'b1}}
) (
  input  logic               clk,
  input  logic               clr,
  output logic [ADDR_W-1:0]  mem_addr,
  input  logic [WORD_W-1:0]  instr_word,
  output logic [CNT_BUS-1:0] type_counts,
  output logic [COUNT_W-1:0] total_count,
  output logic               done
);
  logic              at_end_word;
  logic              at_last_row;
  logic              step;
  logic [TYPE_W-1:0] cls_code;
  logic              cls_hit;
  logic [NTYPES-1:0] cls_en;
  logic [NTYPES-1:0][COUNT_W-1:0] cnt_q;

  assign at_end_word = (instr_word == END_WORD);
  assign at_last_row = (mem_addr == LAST_ROW);
  assign step        = !done && !at_end_word;

  // Address walk and stop control
  always_ff @(posedge clk) begin
    if (clr) begin
      mem_addr <= '0;
      done     <= 1'b0;
    end else if (!done) begin
      if (at_end_word || at_last_row) begin
        done <= 1'b1;
      end else begin
        mem_addr <= mem_addr + 1'b1;
      end
    end
  end

  mix_classifier u_cls (
    .word_lo  (instr_word[11:0]),
    .cls_code (cls_code),
    .cls_hit  (cls_hit)
  );

  mix_decoder #(.SEL_W(TYPE_W)) u_dec (
    .en     (step && cls_hit),
    .sel    (cls_code),
    .onehot (cls_en)
  );

  for (genvar g = 0; g < NTYPES; g++) begin : g_cls_cnt
    mix_sat_counter #(.W(COUNT_W)) u_cnt (
      .clk   (clk),
      .clr   (clr),
      .inc   (cls_en[g]),
      .count (cnt_q[g])
    );
  end

  mix_sat_counter #(.W(COUNT_W)) u_total (
    .clk   (clk),
    .clr   (clr),
    .inc   (step),
    .count (total_count)
  );

  assign type_counts = cnt_q;

  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (clr)
    done |=> done);

  assert_frozen_after_done_R7: assert property (@(posedge clk) disable iff (clr)
    done |=> ($stable(mem_addr) && $stable(total_count) && $stable(cnt_q)));

  assert_end_word_stops_R6: assert property (@(posedge clk) disable iff (clr)
    (!done && at_end_word) |=> (done && $stable(total_count) && $stable(mem_addr)));

  assert_addr_steps_R2: assert property (@(posedge clk) disable iff (clr)
    (!done && !at_end_word && !at_last_row) |=>
      (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

  assert_last_row_stop_R8: assert property (@(posedge clk) disable iff (clr)
    (!done && !at_end_word && at_last_row) |=> (done && mem_addr == LAST_ROW));
endmodule

// File: tb/tb_instr_mix_counter.sv
module tb_instr_mix_counter;
  logic         clk = 1'b0;
  logic         clr = 1'b1;
  logic [7:0]   mem_addr;
  logic [31:0]  instr_word;
  logic [127:0] type_counts;
  logic [15:0]  total_count;
  logic         done;

  logic [3:0]   n_addr;
  logic [31:0]  n_counts;
  logic [3:0]   n_total;
  logic         n_done;

  logic [31:0] mem [256];
  int          kind [256];   // 0..7 class, 8 unknown, 9 end word

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  assign instr_word = mem[mem_addr];

  instr_mix_counter dut (
    .clk(clk), .clr(clr), .mem_addr(mem_addr), .instr_word(instr_word),
    .type_counts(type_counts), .total_count(total_count), .done(done)
  );

  // Narrow instance fed only ALU-immediate words, to reach saturation.
  instr_mix_counter #(.ADDR_W(4), .COUNT_W(4)) dut_narrow (
    .clk(clk), .clr(clr), .mem_addr(n_addr), .instr_word(32'h00A0_0513),
    .type_counts(n_counts), .total_count(n_total), .done(n_done)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] make_word(int k);
    logic [31:0] w = $urandom;
    case (k)
      0: w[6:0] = 7'h13;
      1: w[6:0] = 7'h33;
      2: w[6:0] = 7'h03;
      3: w[6:0] = 7'h23;
      4: w[6:0] = 7'h63;
      5: begin w[6:0] = 7'h6F; if (w[11:7] == 5'd0) w[11:7] = 5'd1; end
      6: begin w[6:0] = 7'h6F; w[11:7] = 5'd0; end
      7: w[6:0] = 7'h67;
      8: w[6:0] = w[0] ? 7'h37 : 7'h17;
      default: w = 32'hC000_1073;
    endcase
    return w;
  endfunction

  function automatic int cnt_of(int k);
    return int'(type_counts[k*16 +: 16]);
  endfunction

  task automatic put(int i, int k);
    kind[i] = k;
    mem[i]  = make_word(k);
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1'b1;
    @(posedge clk);
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic wait_done();
    int guard = 0;
    while (!done && guard < 300) begin
      @(negedge clk);
      guard++;
    end
    chk("R6/R8 done reached", int'(done), 1);
  endtask

  task automatic check_program(string tag);
    int exp_cnt [8];
    int exp_total = 0;
    int exp_addr = 255;
    foreach (exp_cnt[k]) exp_cnt[k] = 0;
    for (int i = 0; i < 256; i++) begin
      if (kind[i] == 9) begin exp_addr = i; break; end
      exp_total++;
      if (kind[i] < 8) exp_cnt[kind[i]]++;
    end
    for (int k = 0; k < 8; k++)
      chk($sformatf("R3 R4 %s class %0d count", tag, k), cnt_of(k), exp_cnt[k]);
    chk({"R10 R5 total ", tag}, int'(total_count), exp_total);
    chk({"R6 R8 final address ", tag}, int'(mem_addr), exp_addr);
  endtask

  task automatic fill_random(int end_at);
    for (int i = 0; i < 256; i++) put(i, $urandom_range(0, 8));
    if (end_at >= 0) put(end_at, 9);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    int snap_total;
    int snap_addr;
    int snap_c0;
    void'($urandom(32'd2718));

    // Directed program: every class once, unknowns, near-end words, end word
    for (int i = 0; i < 256; i++) begin kind[i] = 0; mem[i] = 32'h0000_0013; end
    for (int k = 0; k < 8; k++) put(k, k);
    kind[8] = 8; mem[8] = 32'hC000_1072;   // R6 one bit off the end word
    kind[9] = 8; mem[9] = 32'hC000_1173;   // R6 another near miss
    put(10, 9);

    @(negedge clk);
    @(negedge clk);
    clr = 1'b0;
    do_clear();
    chk("R1 address after clear", int'(mem_addr), 0);
    chk("R1 done after clear", int'(done), 0);
    chk("R1 total after clear", int'(total_count), 0);
    chk("R1 class counts after clear", int'(type_counts != 128'd0), 0);

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R2 address after three edges", int'(mem_addr), 3);
    chk("R10 total after three edges", int'(total_count), 3);
    chk("R4 class 1 after three edges", cnt_of(1), 1);
    chk("R4 class 3 untouched so far", cnt_of(3), 0);

    wait_done();
    check_program("directed");
    chk("R5 total exceeds class sum by two", int'(total_count) -
        (cnt_of(0)+cnt_of(1)+cnt_of(2)+cnt_of(3)+cnt_of(4)+cnt_of(5)+cnt_of(6)+cnt_of(7)), 2);
    chk("R3 jump with zero dest is class 6", cnt_of(6), 1);

    // R7: frozen while done
    snap_total = int'(total_count); snap_addr = int'(mem_addr); snap_c0 = cnt_of(0);
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk("R7 done held", int'(done), 1);
    chk("R7 address held", int'(mem_addr), snap_addr);
    chk("R7 total held", int'(total_count), snap_total);
    chk("R7 class 0 held", cnt_of(0), snap_c0);

    // R9: narrow instance has run well past 15 words
    chk("R9 narrow class 0 saturated", int'(n_counts[3:0]), 15);
    chk("R9 narrow total saturated", int'(n_total), 15);
    chk("R9 narrow other classes zero", int'(n_counts[31:4]), 0);

    // Random programs with an end word somewhere
    for (int r = 0; r < 5; r++) begin
      fill_random($urandom_range(1, 200));
      do_clear();
      wait_done();
      check_program($sformatf("random%0d", r));
    end

    // End word at the first row
    fill_random(0);
    do_clear();
    @(negedge clk);
    chk("R6 end word at row 0 sets done", int'(done), 1);
    check_program("end at row 0");

    // No end word anywhere: last row counted
    fill_random(-1);
    do_clear();
    wait_done();
    check_program("no end word");
    chk("R8 total equals all rows", int'(total_count), 256);

    // Clear after done restarts
    do_clear();
    chk("R1 clear after done", int'(done), 0);
    chk("R1 address after reclear", int'(mem_addr), 0);

    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule